// File: doc/BRIEF.md
# Address Translation Window Mapper

This block turns the address of a memory-mapped read or write into the parameters of an outbound request. A build-time number of translation windows is held in registers. Each window has a base, a mask, a replacement offset and a control word. The control word holds an enable bit, a write packet kind, a request priority and a target destination ID. For every presented access, the block finds the lowest-numbered enabled window whose masked base equals the masked address. It then forms the translated address and returns the header fields of that window one clock later. An access that no window claims returns an error strobe instead of a result.

Software programs the windows through a narrow write port. The port carries a window index, a register selector and a data word. A small lookup state machine drives the response. It has three states: `LK_IDLE` (no result this cycle), `LK_HIT` (a translated request is presented) and `LK_MISS` (the access was refused). On every clock edge it moves to `LK_HIT` when an access is presented and a window matches. It moves to `LK_MISS` when an access is presented and nothing matches. It moves to `LK_IDLE` when no access is presented. These transitions apply from any state.

Top module: `xlat_window_mapper`

## Requirements
- R1: After reset every window is disabled, so each access yields `rsp_err` and never `rsp_valid`.
- R2: A configuration write with `cfg_reg` 0 sets the base, 1 sets the mask, 2 sets the offset and 3 sets the control word of window `cfg_win`. A write whose `cfg_win` is NUM_WIN or above changes no window.
- R3: The control word places the enable bit at bit 0, the write kind at bits 2:1, the priority at bits 4:3 and the destination ID at bits 12:5. The last two are presented on `rsp_prio` and `rsp_dest`.
- R4: A window matches when it is enabled and `acc_addr & mask` equals `base & mask`.
- R5: The translated address `rsp_addr` takes the offset bits where the mask is 1 and the access address bits where the mask is 0.
- R6: When several windows match, the lowest-numbered one is used, and its index appears on `rsp_win`.
- R7: Write kind code 0 is a plain write, 1 is a write with response and 2 is a streaming write; it appears on `rsp_wkind`. A window holding code 3 never matches.
- R8: An access matched by no window raises `rsp_err` for one cycle with `rsp_valid` low and all result fields zero.
- R9: The result of an access appears exactly one cycle after `acc_valid`. A cycle without `acc_valid` produces neither `rsp_valid` nor `rsp_err` in the following cycle.
- R10: Clearing the enable bit of a window removes it from matching. A lower-priority overlapping window then takes over its addresses.
- R11: When a configuration write and an access fall in the same cycle, the lookup uses the window contents from before the write. The write applies from the next access on.
- R12: `rsp_write` repeats the `acc_write` value of the access that produced the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | WSEL_W | Window index of the configuration write |
| cfg_reg | input | 2 | Register selector: 0 base, 1 mask, 2 offset, 3 control |
| cfg_wdata | input | ADDR_W | Configuration write data |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | ADDR_W | Access address |
| rsp_valid | output | 1 | Translated request available |
| rsp_err | output | 1 | Access matched no window |
| rsp_write | output | 1 | Direction of the translated access |
| rsp_win | output | IDX_W | Index of the selected window |
| rsp_addr | output | ADDR_W | Translated address |
| rsp_dest | output | DEST_W | Destination ID of the selected window |
| rsp_prio | output | PRIO_W | Request priority of the selected window |
| rsp_wkind | output | 2 | Write packet kind of the selected window |

## Verification
A register update and a lookup can land in the same cycle. The bench provokes this by presenting an access into window 0 while, in the same cycle, writing a control word that disables that window. The result must still show the old hit with its old header fields, and the next access to the same address must be refused. Priority between overlapping windows is judged by a sweep of probe addresses that is repeated after a window is disabled. Each result is compared with a lookup computed in the bench from the programmed values.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        WK_PLAIN  = 2'd0,
        WK_RESP   = 2'd1,
        WK_STREAM = 2'd2,
        WK_RSVD   = 2'd3
    } wkind_e;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_CTRL   = 2'd3
    } regsel_e;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HIT  = 2'd1,
        LK_MISS = 2'd2
    } lk_state_e;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_KIND_LSB = 1;
    localparam int CTL_PRIO_LSB = 3;

endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
    import xlat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEST_W = 8,
    parameter int PRIO_W = 2,
    parameter int WSEL_W = 3,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WSEL_W-1:0] cfg_win,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] mask_q,
    output logic [ADDR_W-1:0] offs_q,
    output logic              en_q,
    output logic [1:0]        kind_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [DEST_W-1:0] dest_q
);

    localparam int DEST_LSB = CTL_PRIO_LSB + PRIO_W;

    logic mine;
    assign mine = cfg_we && (cfg_win == WSEL_W'(MY_IDX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            offs_q <= '0;
            en_q   <= 1'b0;
            kind_q <= 2'd0;
            prio_q <= '0;
            dest_q <= '0;
        end else if (mine) begin
            unique case (regsel_e'(cfg_reg))
                SEL_BASE:   base_q <= cfg_wdata;
                SEL_MASK:   mask_q <= cfg_wdata;
                SEL_OFFSET: offs_q <= cfg_wdata;
                SEL_CTRL: begin
                    en_q   <= cfg_wdata[CTL_EN_BIT];
                    kind_q <= cfg_wdata[CTL_KIND_LSB +: 2];
                    prio_q <= cfg_wdata[CTL_PRIO_LSB +: PRIO_W];
                    dest_q <= cfg_wdata[DEST_LSB +: DEST_W];
                end
            endcase
        end
    end

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 32,
    parameter int DEST_W  = 8,
    parameter int PRIO_W  = 2,
    parameter int IDX_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] base_a,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] mask_a,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] offs_a,
    input  logic [NUM_WIN-1:0]             en_a,
    input  logic [NUM_WIN-1:0][1:0]        kind_a,
    input  logic [NUM_WIN-1:0][PRIO_W-1:0] prio_a,
    input  logic [NUM_WIN-1:0][DEST_W-1:0] dest_a,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               sel_idx,
    output logic [ADDR_W-1:0]              xaddr,
    output logic [DEST_W-1:0]              dest,
    output logic [PRIO_W-1:0]              prio,
    output logic [1:0]                     kind
);

    logic [NUM_WIN-1:0] hit_v;

    // per-window comparators
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign hit_v[w] = en_a[w]
                       && (kind_a[w] != 2'(WK_RSVD))
                       && ((addr & mask_a[w]) == (base_a[w] & mask_a[w]));
    end

    // lowest index wins
    always_comb begin
        sel_idx = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_v[w]) sel_idx = IDX_W'(w);
        end
    end

    assign any_hit = |hit_v;
    assign xaddr   = (offs_a[sel_idx] & mask_a[sel_idx]) | (addr & ~mask_a[sel_idx]);
    assign dest    = dest_a[sel_idx];
    assign prio    = prio_a[sel_idx];
    assign kind    = kind_a[sel_idx];

    logic lower_hit;
    always_comb begin
        lower_hit = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if ((w < int'(sel_idx)) && hit_v[w]) lower_hit = 1'b1;
        end
    end

    assert_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_v[sel_idx] && !lower_hit));

    assert_usable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (en_a[sel_idx] && kind != 2'(WK_RSVD)));

    assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (((xaddr ^ addr) & ~mask_a[sel_idx]) == '0));

endmodule

// File: rtl/xlat_window_mapper.sv
module xlat_window_mapper
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int ADDR_W  = 32,
    parameter int DEST_W  = 8,
    parameter int PRIO_W  = 2,
    parameter int WSEL_W  = $clog2(NUM_WIN) + 1,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WSEL_W-1:0] cfg_win,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_write,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DEST_W-1:0] rsp_dest,
    output logic [PRIO_W-1:0] rsp_prio,
    output logic [1:0]        rsp_wkind
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_a, mask_a, offs_a;
    logic [NUM_WIN-1:0]             en_a;
    logic [NUM_WIN-1:0][1:0]        kind_a;
    logic [NUM_WIN-1:0][PRIO_W-1:0] prio_a;
    logic [NUM_WIN-1:0][DEST_W-1:0] dest_a;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlat_win_regs #(
            .ADDR_W(ADDR_W), .DEST_W(DEST_W), .PRIO_W(PRIO_W),
            .WSEL_W(WSEL_W), .MY_IDX(w)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we),
            .cfg_win  (cfg_win),
            .cfg_reg  (cfg_reg),
            .cfg_wdata(cfg_wdata),
            .base_q   (base_a[w]),
            .mask_q   (mask_a[w]),
            .offs_q   (offs_a[w]),
            .en_q     (en_a[w]),
            .kind_q   (kind_a[w]),
            .prio_q   (prio_a[w]),
            .dest_q   (dest_a[w])
        );
    end

    logic              any_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] xaddr;
    logic [DEST_W-1:0] sel_dest;
    logic [PRIO_W-1:0] sel_prio;
    logic [1:0]        sel_kind;

    xlat_pick #(
        .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .DEST_W(DEST_W),
        .PRIO_W(PRIO_W), .IDX_W(IDX_W)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (acc_addr),
        .base_a (base_a),
        .mask_a (mask_a),
        .offs_a (offs_a),
        .en_a   (en_a),
        .kind_a (kind_a),
        .prio_a (prio_a),
        .dest_a (dest_a),
        .any_hit(any_hit),
        .sel_idx(sel_idx),
        .xaddr  (xaddr),
        .dest   (sel_dest),
        .prio   (sel_prio),
        .kind   (sel_kind)
    );

    // lookup state machine
    lk_state_e state_q, state_d;

    always_comb begin
        unique case ({acc_valid, any_hit})
            2'b11:   state_d = LK_HIT;
            2'b10:   state_d = LK_MISS;
            default: state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // result capture
    logic              wr_q;
    logic [IDX_W-1:0]  win_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DEST_W-1:0] dest_q;
    logic [PRIO_W-1:0] prio_q;
    logic [1:0]        kind_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            win_q  <= '0;
            addr_q <= '0;
            dest_q <= '0;
            prio_q <= '0;
            kind_q <= 2'd0;
        end else if (acc_valid && any_hit) begin
            wr_q   <= acc_write;
            win_q  <= sel_idx;
            addr_q <= xaddr;
            dest_q <= sel_dest;
            prio_q <= sel_prio;
            kind_q <= sel_kind;
        end
    end

    // outputs per state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_write = 1'b0;
        rsp_win   = '0;
        rsp_addr  = '0;
        rsp_dest  = '0;
        rsp_prio  = '0;
        rsp_wkind = 2'd0;
        unique case (state_q)
            LK_HIT: begin
                rsp_valid = 1'b1;
                rsp_write = wr_q;
                rsp_win   = win_q;
                rsp_addr  = addr_q;
                rsp_dest  = dest_q;
                rsp_prio  = prio_q;
                rsp_wkind = kind_q;
            end
            LK_MISS: rsp_err = 1'b1;
            default: ;
        endcase
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || rsp_err) |-> $past(acc_valid));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(rsp_valid || rsp_err));

    assert_echo_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_write == $past(acc_write)));

    assert_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !any_hit) |=> (rsp_err && rsp_addr == '0));

endmodule

// File: tb/xlat_window_mapper_tb.sv
module xlat_window_mapper_tb;

    localparam int NW = 4;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        rsp_valid, rsp_err, rsp_write;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;
    logic [7:0]  rsp_dest;
    logic [1:0]  rsp_prio;
    logic [1:0]  rsp_wkind;

    always #5 clk = ~clk;

    xlat_window_mapper u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_write(rsp_write),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_dest(rsp_dest),
        .rsp_prio(rsp_prio), .rsp_wkind(rsp_wkind)
    );

    int total = 0;
    int bad = 0;

    // bench-side window model
    logic [31:0] m_base [NW];
    logic [31:0] m_mask [NW];
    logic [31:0] m_offs [NW];
    logic        m_en   [NW];
    logic [1:0]  m_kind [NW];
    logic [1:0]  m_prio [NW];
    logic [7:0]  m_dest [NW];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int win, input int rsel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'(win); cfg_reg = 2'(rsel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (win < NW) begin
            case (rsel)
                0: m_base[win] = data;
                1: m_mask[win] = data;
                2: m_offs[win] = data;
                default: begin
                    m_en[win]   = data[0];
                    m_kind[win] = data[2:1];
                    m_prio[win] = data[4:3];
                    m_dest[win] = data[12:5];
                end
            endcase
        end
    endtask

    function automatic logic [31:0] ctl(input int en, input int kind, input int prio, input int dest);
        return 32'((dest << 5) | (prio << 3) | (kind << 1) | en);
    endfunction

    // compare outputs with model lookup for an address
    task automatic judge(input logic [31:0] a, input logic wr, input string tag);
        int  sel = -1;
        for (int w = NW - 1; w >= 0; w--)
            if (m_en[w] && m_kind[w] != 2'd3 && ((a & m_mask[w]) == (m_base[w] & m_mask[w])))
                sel = w;
        if (sel < 0) begin
            chk(rsp_err === 1'b1 && rsp_valid === 1'b0, {tag, " R8 miss"}, {30'd0, rsp_valid, rsp_err}, 32'd1);
            chk(rsp_addr === 32'd0, {tag, " R8 zero addr"}, rsp_addr, 32'd0);
        end else begin
            logic [31:0] xa;
            xa = (m_offs[sel] & m_mask[sel]) | (a & ~m_mask[sel]);
            chk(rsp_valid === 1'b1 && rsp_err === 1'b0, {tag, " R4 hit"}, {30'd0, rsp_valid, rsp_err}, 32'd2);
            chk(rsp_win === 2'(sel), {tag, " R6 window"}, 32'(rsp_win), 32'(sel));
            chk(rsp_addr === xa, {tag, " R5 addr"}, rsp_addr, xa);
            chk(rsp_dest === m_dest[sel] && rsp_prio === m_prio[sel], {tag, " R3 header"},
                {22'd0, rsp_prio, rsp_dest}, {22'd0, m_prio[sel], m_dest[sel]});
            chk(rsp_wkind === m_kind[sel], {tag, " R7 kind"}, 32'(rsp_wkind), 32'(m_kind[sel]));
            chk(rsp_write === wr, {tag, " R12 direction"}, 32'(rsp_write), 32'(wr));
        end
    endtask

    task automatic access(input logic [31:0] a, input logic wr, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0;
        judge(a, wr, tag);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = (32'((i >> 4) + 1) << 28) | (32'(i & 15) << 20) | (32'(i * 32'h1357) & 32'h000F_FFFF);
            access(a, 1'(i), tag);
        end
    endtask

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_base[w] = '0; m_mask[w] = '0; m_offs[w] = '0;
            m_en[w] = 1'b0; m_kind[w] = '0; m_prio[w] = '0; m_dest[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all windows off after reset
        access(32'h1000_0000, 1'b1, "R1 reset");
        access(32'h0000_0000, 1'b0, "R1 reset");

        // program windows (R2, R3)
        cfg_write(0, 0, 32'h1000_0000); cfg_write(0, 1, 32'hFFFF_0000);
        cfg_write(0, 2, 32'hA000_0000); cfg_write(0, 3, ctl(1, 0, 1, 8'h11));
        cfg_write(1, 0, 32'h2000_0000); cfg_write(1, 1, 32'hFF00_0000);
        cfg_write(1, 2, 32'h0500_0000); cfg_write(1, 3, ctl(1, 1, 2, 8'h22));
        cfg_write(2, 0, 32'h2010_0000); cfg_write(2, 1, 32'hFFF0_0000);
        cfg_write(2, 2, 32'h7770_0000); cfg_write(2, 3, ctl(1, 2, 3, 8'h33));
        cfg_write(3, 0, 32'h3000_0000); cfg_write(3, 1, 32'hF000_0000);
        cfg_write(3, 2, 32'hC000_0000); cfg_write(3, 3, ctl(1, 3, 0, 8'h44));

        // window edges
        access(32'h1000_0000, 1'b1, "R4 lower edge");
        access(32'h1000_FFFF, 1'b0, "R5 upper edge");
        access(32'h1001_0000, 1'b1, "R4 just past");
        access(32'h2010_0ABC, 1'b1, "R6 overlap");
        access(32'h3123_4567, 1'b0, "R7 reserved kind");

        // R9: idle cycle after an access
        @(negedge clk);
        chk(rsp_valid === 1'b0 && rsp_err === 1'b0, "R9 idle", {30'd0, rsp_valid, rsp_err}, 32'd0);

        sweep("R4 sweep A");

        // R2: writes to nonexistent windows change nothing
        cfg_write(4, 3, ctl(1, 2, 0, 8'hEE));
        cfg_write(4, 2, 32'h0000_0000);
        cfg_write(7, 0, 32'h5000_0000);
        access(32'h1000_1234, 1'b1, "R2 out of range");

        // R7 kind 1 on window 3; R10 disable window 1
        cfg_write(3, 3, ctl(1, 1, 3, 8'h44));
        cfg_write(1, 3, ctl(0, 1, 2, 8'h22));
        access(32'h2010_0ABC, 1'b0, "R10 takeover");
        access(32'h2200_0000, 1'b0, "R10 disabled");
        sweep("R7 sweep B");

        // R11: write and access in the same cycle
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 32'h1000_4321; acc_write = 1'b1;
        cfg_we = 1'b1; cfg_win = 3'd0; cfg_reg = 2'd3; cfg_wdata = ctl(0, 0, 1, 8'h11);
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b0;
        judge(32'h1000_4321, 1'b1, "R11 old contents");
        m_en[0] = 1'b0;
        access(32'h1000_4321, 1'b1, "R11 new contents");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule